// File: doc/BRIEF.md
# Sectionable 24-Stage Event Counter

This block counts high-to-low transitions of a slow count input and presents the running total as a 24-bit value. The count input is brought into the system clock domain through a short synchronizer. Each falling edge found there becomes a single-cycle advance strobe, so every flop in the block runs on the system clock.

Two level controls shape the behaviour: a clear control and a set control. Clear alone empties the counter. Both controls high together split the chain into three 8-bit sections. Every advance strobe steps all three sections at once and no carry passes between them. From zero, 255 falling edges then drive every stage to 1, which is far fewer than the 2^24 counts a single chain would need.

Dropping both controls together rejoins the sections into one chain and keeps their contents. A single further falling edge then carries through all 24 stages, and the block raises a one-cycle terminal pulse as the chain wraps to zero.

Top module: `seg_counter`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it is released, `count_q` is 0, `sect_mode` is 0 and `wrap_pulse` is 0.
- R2: In chained mode, each high-to-low transition of `cnt_in` adds 1 modulo 2^24 to `count_q`. The new value appears on the third rising clock edge counting from the first edge that samples `cnt_in` low. Rising transitions and steady levels of `cnt_in` leave `count_q` unchanged.
- R3: On an edge that samples `clr_in`=1 and `set_in`=0, `count_q` becomes 0. This clear overrides any advance due on the same edge.
- R4: `sect_mode` becomes 1 on an edge that samples `set_in`=1 and `clr_in`=1. It becomes 0 on an edge that samples `set_in`=0, whatever the value of `clr_in`.
- R5: While `sect_mode` is 1, each high-to-low transition of `cnt_in` adds 1 modulo 256 to each of the fields `count_q[7:0]`, `count_q[15:8]` and `count_q[23:16]`. Each field wraps from 255 to 0 and passes no carry to the next field.
- R6: Starting from `count_q`=0 in sectioned mode, 255 falling transitions of `cnt_in` give `count_q`=24'hFFFFFF.
- R7: When `set_in` and `clr_in` fall from 1 to 0 together, `sect_mode` drops to 0 and `count_q` keeps its value.
- R8: On an edge that samples `set_in`=1 and `clr_in`=0, `sect_mode` and `count_q` do not change, and later falling transitions count in whichever mode was already in force.
- R9: `wrap_pulse` is 1 for exactly the one cycle in which a chained-mode advance takes `count_q` from 24'hFFFFFF to 0. It stays 0 when the sections wrap in sectioned mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Asynchronous count input; its falling edges advance the counter |
| set_in | input | 1 | Set control; with `clr_in` high, selects sectioned mode |
| clr_in | input | 1 | Clear control; alone, clears the counter |
| count_q | output | 24 | Registered counter state |
| sect_mode | output | 1 | High while the counter runs as three 8-bit sections |
| wrap_pulse | output | 1 | One-cycle pulse when the 24-bit chain wraps to zero |

## Verification
A falling edge of `cnt_in` reaches `count_q` and `wrap_pulse` three rising edges after the first edge that samples the low level: two synchronizer flops, then the counter register. A change on `set_in` or `clr_in` reaches `count_q` and `sect_mode` at the very next edge. The bench drives inputs on the falling clock edge. It holds each `cnt_in` level for four cycles and waits two cycles after a control change, so every result has settled before the bench samples it on a falling edge. Expected values come from a bench model stepped once per stimulus. `wrap_pulse` is counted on every falling edge, so a pulse that is missing or appears twice is caught.

// File: rtl/segctr_pkg.sv
package segctr_pkg;

  // Control word is {set_in, clr_in}
  typedef enum logic [1:0] {
    CTL_RUN   = 2'b00,
    CTL_CLR   = 2'b01,
    CTL_HOLD  = 2'b10,
    CTL_SPLIT = 2'b11
  } ctl_e;

  function automatic ctl_e ctl_decode(input logic set_v, input logic clr_v);
    return ctl_e'({set_v, clr_v});
  endfunction

endpackage

// File: rtl/segctr_edge_det.sv
module segctr_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);

  // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1;
    end else begin
      sh <= {sh[STAGES-1:0], din};
    end
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/segctr_mode.sv
module segctr_mode
  import segctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic clr_in,
  output logic sect_q,
  output logic clr_now
);

  ctl_e ctl;

  always_comb begin
    ctl     = ctl_decode(set_in, clr_in);
    clr_now = (ctl == CTL_CLR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sect_q <= 1'b0;
    end else begin
      unique case (ctl)
        CTL_SPLIT: sect_q <= 1'b1;
        CTL_HOLD:  sect_q <= sect_q;
        CTL_RUN,
        CTL_CLR:   sect_q <= 1'b0;
        default:   sect_q <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/segctr_section.sv
module segctr_section #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         full
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (en) begin
      q <= q + 1'b1;
    end
  end

  assign full = &q;

endmodule

// File: rtl/seg_counter.sv
module seg_counter #(
  parameter int unsigned SEC_W       = 8,
  parameter int unsigned SEC_N       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TOT_W      = SEC_W * SEC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_in,
  input  logic             set_in,
  input  logic             clr_in,
  output logic [TOT_W-1:0] count_q,
  output logic             sect_mode,
  output logic             wrap_pulse
);

  logic             fall_stb;
  logic             clr_now;
  logic             sect_q;
  logic [SEC_N-1:0] sec_en;
  logic [SEC_N-1:0] sec_full;
  logic             chain_wrap;
  logic             wrap_q;

  segctr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (cnt_in),
    .fall (fall_stb)
  );

  segctr_mode u_mode (
    .clk     (clk),
    .rst     (rst),
    .set_in  (set_in),
    .clr_in  (clr_in),
    .sect_q  (sect_q),
    .clr_now (clr_now)
  );

  for (genvar i = 0; i < SEC_N; i++) begin : g_sec
    if (i == 0) begin : g_first
      assign sec_en[i] = fall_stb;
    end else begin : g_next
      // sectioned: every section sees the strobe; chained: ripple carry
      assign sec_en[i] = sect_q ? fall_stb : (sec_en[i-1] & sec_full[i-1]);
    end

    segctr_section #(.W(SEC_W)) u_sec (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr_now),
      .en   (sec_en[i]),
      .q    (count_q[i*SEC_W +: SEC_W]),
      .full (sec_full[i])
    );
  end

  assign chain_wrap = fall_stb & ~sect_q & (&sec_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= chain_wrap & ~clr_now;
    end
  end

  assign sect_mode  = sect_q;
  assign wrap_pulse = wrap_q;

endmodule

// File: rtl/seg_counter_chk.sv
module seg_counter_chk #(
  parameter int unsigned SEC_W = 8,
  parameter int unsigned SEC_N = 3,
  localparam int unsigned TOT_W = SEC_W * SEC_N
) (
  input logic             clk,
  input logic             rst,
  input logic             set_in,
  input logic             clr_in,
  input logic             fall,
  input logic [TOT_W-1:0] count_q,
  input logic             sect_mode,
  input logic             wrap_pulse
);

  logic clr_c;
  assign clr_c = clr_in & ~set_in;

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_c |=> (count_q == '0));

  // R4
  split_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (set_in && clr_in) |=> sect_mode);

  // R4
  split_leave_chk: assert property (@(posedge clk) disable iff (rst)
    !set_in |=> !sect_mode);

  // R8
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (set_in && !clr_in) |=> $stable(sect_mode));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall && !clr_c) |=> $stable(count_q));

  // R2
  chain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && !clr_c && !sect_mode) |=> (count_q == $past(count_q) + 1'b1));

  // R5
  for (genvar i = 0; i < SEC_N; i++) begin : g_sec_chk
    sect_step_chk: assert property (@(posedge clk) disable iff (rst)
      (fall && !clr_c && sect_mode) |=>
        (count_q[i*SEC_W +: SEC_W] == $past(count_q[i*SEC_W +: SEC_W]) + 1'b1));
  end

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (count_q == '0));

  // R9
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse);

  // R9
  wrap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && !clr_c && !sect_mode && (count_q == '1)) |=> wrap_pulse);

endmodule

bind seg_counter seg_counter_chk #(.SEC_W(SEC_W), .SEC_N(SEC_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .set_in     (set_in),
  .clr_in     (clr_in),
  .fall       (fall_stb),
  .count_q    (count_q),
  .sect_mode  (sect_mode),
  .wrap_pulse (wrap_pulse)
);

// File: tb/tb_seg_counter.sv
`timescale 1ns/1ps
module tb_seg_counter;

  localparam int unsigned SEC_W = 8;
  localparam int unsigned SEC_N = 3;
  localparam int unsigned TOT_W = SEC_W * SEC_N;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cnt_in = 1'b1;
  logic             set_in = 1'b0;
  logic             clr_in = 1'b0;
  logic [TOT_W-1:0] count_q;
  logic             sect_mode;
  logic             wrap_pulse;

  int checks = 0;
  int errors = 0;
  int wraps  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [TOT_W-1:0] exp_cnt  = '0;
  bit               exp_sect = 1'b0;

  always #2.5 clk = ~clk;

  seg_counter #(.SEC_W(SEC_W), .SEC_N(SEC_N)) dut (
    .clk        (clk),
    .rst        (rst),
    .cnt_in     (cnt_in),
    .set_in     (set_in),
    .clr_in     (clr_in),
    .count_q    (count_q),
    .sect_mode  (sect_mode),
    .wrap_pulse (wrap_pulse)
  );

  always @(negedge clk) begin
    if (!rst && wrap_pulse) wraps++;
  end

  function automatic logic [TOT_W-1:0] step(input logic [TOT_W-1:0] c, input bit sect);
    logic [TOT_W-1:0] n;
    if (!sect) return c + 1'b1;
    n = c;
    for (int i = 0; i < SEC_N; i++) n[i*SEC_W +: SEC_W] = c[i*SEC_W +: SEC_W] + 1'b1;
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [TOT_W-1:0] act,
                       input logic [TOT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one falling then rising transition of cnt_in; model advances once
  task automatic pulse();
    cnt_in = 1'b0;
    idle(4);
    cnt_in = 1'b1;
    idle(4);
    if (exp_sect && !(clr_in && !set_in)) exp_cnt = step(exp_cnt, 1'b1);
    else if (!(clr_in && !set_in)) exp_cnt = step(exp_cnt, 1'b0);
  endtask

  task automatic ctl(input bit s, input bit c);
    set_in = s;
    clr_in = c;
    idle(2);
    if (c && !s) exp_cnt = '0;
    if (s && c) exp_sect = 1'b1;
    else if (!s) exp_sect = 1'b0;
  endtask

  task automatic check_state(input string tag);
    check(count_q == exp_cnt, tag, count_q, exp_cnt);
    check(sect_mode == exp_sect, {tag, " mode"}, TOT_W'(sect_mode), TOT_W'(exp_sect));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    idle(3);
    // R1 reset state
    check(count_q == '0, "R1 count", count_q, '0);
    check(sect_mode == 1'b0, "R1 mode", TOT_W'(sect_mode), '0);
    check(wrap_pulse == 1'b0, "R1 wrap", TOT_W'(wrap_pulse), '0);
    rst = 1'b0;
    @(negedge clk);
    check(count_q == '0 && !sect_mode && !wrap_pulse, "R1 release", count_q, '0);

    // R2 chained counting, rising edge only has no effect
    pulse(); pulse(); pulse();
    check_state("R2 three falls");
    cnt_in = 1'b0; idle(4);
    exp_cnt = step(exp_cnt, 1'b0);
    check_state("R2 fall latency");
    idle(5);
    check_state("R2 steady low");
    cnt_in = 1'b1; idle(6);
    check_state("R2 rising ignored");

    // R3 clear, overriding a pending advance
    cnt_in = 1'b0; clr_in = 1'b1; idle(6);
    cnt_in = 1'b1; clr_in = 1'b0; idle(4);
    exp_cnt = '0;
    check_state("R3 clear over count");

    // R4/R5/R6 sectioned fill
    ctl(1'b1, 1'b1);
    check_state("R4 enter sections");
    w0 = wraps;
    for (int i = 0; i < 255; i++) pulse();
    check(count_q == 24'hFFFFFF, "R6 fill", count_q, 24'hFFFFFF);
    check_state("R5 fill model");
    // R8 set alone holds sectioned mode
    ctl(1'b1, 1'b0);
    check_state("R8 hold sections");
    ctl(1'b1, 1'b1);
    // R7 both fall together, contents kept
    ctl(1'b0, 1'b0);
    check_state("R7 rejoin");
    check(count_q == 24'hFFFFFF, "R7 kept", count_q, 24'hFFFFFF);
    check(wraps == w0, "R9 no wrap while filling", TOT_W'(wraps), TOT_W'(w0));
    // R9 chained wrap
    pulse();
    check(count_q == '0, "R9 ripple to zero", count_q, '0);
    check(wraps == w0 + 1, "R9 one wrap pulse", TOT_W'(wraps), TOT_W'(w0 + 1));

    // R5 section wrap without carry, no terminal pulse
    ctl(1'b1, 1'b1);
    for (int i = 0; i < 255; i++) pulse();
    w0 = wraps;
    pulse();
    check_state("R5 sections wrap");
    check(count_q == '0, "R5 no carry", count_q, '0);
    check(wraps == w0, "R9 no wrap in sections", TOT_W'(wraps), TOT_W'(w0));

    // R8 set alone in chained mode: counting continues chained
    ctl(1'b0, 1'b0);
    pulse();
    ctl(1'b1, 1'b0);
    pulse(); pulse();
    check_state("R8 hold chained");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 7) pulse();
      else if (r == 7) ctl(1'b1, 1'b1);
      else if (r == 8) ctl(1'b0, 1'b0);
      else ctl(1'b1, 1'b0);
      if (($urandom % 60) == 0) ctl(1'b0, 1'b1);
      check_state("R2 R5 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule